// File: doc/BRIEF.md
# Paged External Memory Bus Master

This block is the only path from a small 8-bit processor core to its data and scratchpad memory. The core hands it a one-cycle load or store request with an 8-bit location number. The block turns that request into a bus transaction of at least three clocks. A slave that needs more time holds the ready input low, and each low cycle adds one clock to the transaction.

The load and store instructions can only name 256 locations. To reach a larger space, the block keeps a page register that supplies every address bit above the low eight. The total address width is a parameter from 8 to 24. While a transaction runs, a stall output holds the core. Read data is captured into a register that the core reads once the stall drops.

Top module: `paged_bus_master`

## Requirements
- R1: After reset, `bus_cyc_o` and `stall_o` are low, `rdata_o` is 0 and the page register is 0.
- R2: A request is accepted when `req_i` is high in a cycle with no transaction in progress. In the next cycle `bus_cyc_o` goes high, and `bus_we_o` and `bus_wdata_o` carry the `we_i` and `wdata_i` values sampled at acceptance (`we_i` = 1 means write).
- R3: `bus_cyc_o` stays high for at least three consecutive cycles: an address cycle, a wait cycle and a completion cycle. If `bus_rdy_i` is high in the completion cycle, `bus_cyc_o` is low in the following cycle. `bus_rdy_i` has no effect in the address and wait cycles.
- R4: For each completion cycle in which `bus_rdy_i` is low, the completion cycle repeats and the transaction lasts one more clock.
- R5: `stall_o` is high in every transaction cycle except a completion cycle that sees `bus_rdy_i` high. It is low whenever `bus_cyc_o` is low.
- R6: `bus_addr_o` equals {page register, `addr_i`}, both sampled at acceptance. The page register fills the bits above bit 7. `bus_addr_o`, `bus_we_o` and `bus_wdata_o` hold steady for the whole transaction.
- R7: When `page_we_i` is high at a clock edge, the page register loads `page_i`. A page write during a transaction leaves that transaction's address unchanged and applies from the next accepted request.
- R8: At the edge that ends the completion cycle of a read, `rdata_o` loads `bus_rdata_i`, and it holds that value until the next read completes. Writes leave `rdata_o` unchanged.
- R9: `req_i` is ignored while a transaction is in progress, including its completion cycle. It neither starts a second transaction nor changes the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Core access request, one-cycle pulse |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 8 | Location within the current page |
| wdata_i | input | 8 | Store data |
| page_we_i | input | 1 | Page register load strobe |
| page_i | input | max(ADDR_W-8,1) | New page value |
| bus_cyc_o | output | 1 | Transaction in progress strobe |
| bus_we_o | output | 1 | Bus write strobe qualifier |
| bus_addr_o | output | ADDR_W | External address |
| bus_wdata_o | output | 8 | External write data |
| bus_rdata_i | input | 8 | External read data |
| bus_rdy_i | input | 1 | Slave transaction-complete |
| rdata_o | output | 8 | Captured read data to the core |
| stall_o | output | 1 | Holds the core while the access is pending |

## Verification
The bench runs reads and writes in three ready patterns. In the first, ready is already high at the completion cycle. In the second, ready is held low for several completion cycles. In the third, ready is high early, during the address and wait cycles. The three patterns show apart a design that finishes in two cycles, one that ignores stretching, and one that samples ready before the completion cycle. `bus_rdata_i` changes every clock, so a capture one cycle early or late shows up as a wrong value in `rdata_o`. The bench also writes the page register in the middle of a transaction and sends requests while one is in progress. These cases separate address capture at acceptance from a live address path, and they catch a design that lets a second request in.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } bus_state_e;
endpackage

// File: rtl/pbm_seq.sv
module pbm_seq
  import pbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rdy_i,
  output logic accept_o,
  output logic finish_o,
  output logic cyc_o,
  output logic stall_o
);
  bus_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign finish_o = (state_q == ST_DONE) && rdy_i;
  assign cyc_o    = (state_q != ST_IDLE);
  assign stall_o  = cyc_o && !finish_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_WAIT;
      ST_WAIT: state_d = ST_DONE;
      ST_DONE: if (rdy_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  AST_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> cyc_o ##1 cyc_o ##1 cyc_o); // R3
  AST_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && stall_o && !rdy_i && $past(cyc_o) && $past(cyc_o, 2)) |=> cyc_o); // R4
  AST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && !stall_o) |=> !cyc_o); // R3
  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_o |-> !stall_o); // R5
endmodule

// File: rtl/pbm_addr.sv
module pbm_addr #(
  parameter int ADDR_W = 16,
  localparam int PAGE_W = ADDR_W - 8,
  localparam int PG_IN_W = (PAGE_W > 0) ? PAGE_W : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               cyc_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               page_we_i,
  input  logic [PG_IN_W-1:0] page_i,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic               bus_we_o,
  output logic [7:0]         bus_wdata_o
);
  logic [ADDR_W-1:0] full_addr;

  generate
    if (PAGE_W > 0) begin : g_page
      logic [PAGE_W-1:0] page_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)        page_q <= '0;
        else if (page_we_i) page_q <= page_i;
      assign full_addr = {page_q, addr_i};
    end else begin : g_flat
      logic unused_page;
      assign unused_page = ^{page_we_i, page_i};
      assign full_addr   = addr_i[ADDR_W-1:0];
    end
  endgenerate

  // capture at acceptance so the bus stays steady under page or core changes
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      bus_addr_o  <= '0;
      bus_we_o    <= 1'b0;
      bus_wdata_o <= '0;
    end else if (accept_i) begin
      bus_addr_o  <= full_addr;
      bus_we_o    <= we_i;
      bus_wdata_o <= wdata_i;
    end

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && $past(cyc_i)) |-> ($stable(bus_addr_o) && $stable(bus_we_o)
                                 && $stable(bus_wdata_o))); // R6
endmodule

// File: rtl/pbm_rdata.sv
module pbm_rdata (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       finish_i,
  input  logic       we_i,
  input  logic [7:0] bus_rdata_i,
  output logic [7:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                rdata_o <= '0;
    else if (finish_i && !we_i) rdata_o <= bus_rdata_i;
endmodule

// File: rtl/paged_bus_master.sv
module paged_bus_master #(
  parameter int ADDR_W = 16,
  localparam int PG_IN_W = (ADDR_W > 8) ? ADDR_W - 8 : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               page_we_i,
  input  logic [PG_IN_W-1:0] page_i,
  output logic               bus_cyc_o,
  output logic               bus_we_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [7:0]         bus_wdata_o,
  input  logic [7:0]         bus_rdata_i,
  input  logic               bus_rdy_i,
  output logic [7:0]         rdata_o,
  output logic               stall_o
);
  logic accept, finish;

  initial begin
    AST_ADDR_W_RANGE: assert (ADDR_W >= 8 && ADDR_W <= 24); // R6
  end

  pbm_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .rdy_i    (bus_rdy_i),
    .accept_o (accept),
    .finish_o (finish),
    .cyc_o    (bus_cyc_o),
    .stall_o  (stall_o)
  );

  pbm_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .cyc_i       (bus_cyc_o),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .page_we_i   (page_we_i),
    .page_i      (page_i),
    .bus_addr_o  (bus_addr_o),
    .bus_we_o    (bus_we_o),
    .bus_wdata_o (bus_wdata_o)
  );

  pbm_rdata u_rdata (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .finish_i    (finish),
    .we_i        (bus_we_o),
    .bus_rdata_i (bus_rdata_i),
    .rdata_o     (rdata_o)
  );

  AST_READ_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !stall_o && !bus_we_o) |=> (rdata_o == $past(bus_rdata_i))); // R8
  AST_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_we_o) |=> $stable(rdata_o)); // R8
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && stall_o) |=> bus_cyc_o); // R9
endmodule

// File: tb/paged_bus_master_test.sv
`timescale 1ns/1ps
module paged_bus_master_test;
  localparam int AW = 16;
  localparam int PW = AW - 8;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, page_we = 0, rdy = 0;
  logic [7:0] addr = 0, wdata = 0, rdata_bus = 0;
  logic [PW-1:0] page = 0;
  logic cyc, bwe, stall;
  logic [AW-1:0] baddr;
  logic [7:0] bwdata, rdata;

  always #10 clk = ~clk;

  paged_bus_master #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .page_we_i(page_we), .page_i(page),
    .bus_cyc_o(cyc), .bus_we_o(bwe), .bus_addr_o(baddr), .bus_wdata_o(bwdata),
    .bus_rdata_i(rdata_bus), .bus_rdy_i(rdy), .rdata_o(rdata), .stall_o(stall));

  int checks = 0, errors = 0;
  // reference model state
  bit m_busy = 0;
  int m_cnt = 0;
  int m_addr = 0, m_we = 0, m_wd = 0, m_page = 0, m_rdata = 0;
  int wait_n = 0;
  bit early = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rdata_bus changes every cycle so a mistimed capture is visible
  always @(negedge clk) rdata_bus <= rdata_bus + 8'h1d;

  // one clock: drive at negedge, compare mid-low phase, update model at posedge
  task automatic step(bit r, bit w, int a, int d, bit pw, int p);
    @(negedge clk);
    req = r; we = w; addr = a[7:0]; wdata = d[7:0]; page_we = pw; page = p[PW-1:0];
    rdy = (m_busy && m_cnt >= 3 + wait_n) || (m_busy && m_cnt < 3 && early);
    #5;
    chk("R3 R4 R9 cyc", cyc, m_busy);
    chk("R5 stall", stall, m_busy && !(m_cnt >= 3 && rdy));
    chk("R8 rdata", rdata, m_rdata);
    if (m_busy) begin
      chk("R6 R7 addr", baddr, m_addr);
      chk("R2 R6 we", bwe, m_we);
      chk("R2 R6 wdata", bwdata, m_wd);
    end
    @(posedge clk);
    if (m_busy) begin
      if (m_cnt >= 3 && rdy) begin
        m_busy = 0;
        if (!m_we) m_rdata = rdata_bus;
      end else m_cnt++;
    end else if (r) begin
      m_busy = 1; m_cnt = 1;
      m_addr = (m_page << 8) | (a & 8'hff);
      m_we = w; m_wd = d & 8'hff;
    end
    if (pw) m_page = p & ((1 << PW) - 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic access(bit w, int a, int d, int wn, bit e);
    wait_n = wn; early = e;
    step(1, w, a, d, 0, 0);
    while (m_busy) step(0, 0, 0, 0, 0, 0);
    idle(1);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35;
    // R1 reset state
    chk("R1 cyc", cyc, 0);
    chk("R1 stall", stall, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1;
    idle(2);
    access(1, 8'h12, 8'ha5, 0, 0);       // write, ready prompt (R3)
    access(0, 8'h34, 0, 0, 0);           // read, prompt
    access(0, 8'h56, 0, 0, 1);           // ready high early, ignored (R3)
    access(0, 8'h78, 0, 4, 0);           // stretched read (R4)
    access(1, 8'h9a, 8'h3c, 2, 1);       // stretched write, rdata kept (R8)
    step(0, 0, 0, 0, 1, 8'hc3); idle(1); // page write (R7)
    access(0, 8'hff, 0, 1, 0);
    chk("R7 page addr", baddr, 16'hc3ff);
    // R7 page change mid-transaction, R9 requests while busy
    wait_n = 2; early = 0;
    step(1, 0, 8'h01, 0, 0, 0);
    step(1, 1, 8'h02, 8'h77, 1, 8'h5a);
    step(1, 1, 8'h03, 8'h66, 0, 0);
    while (m_busy) step(1, 1, 8'h04, 8'h55, 0, 0);
    idle(1);
    access(1, 8'h00, 8'h11, 0, 0);
    chk("R7 new page", baddr, 16'h5a00);
    for (int k = 0; k < 6; k++) access(k[0], k * 37, k * 11, k % 3, k[1]);
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule